// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block carries out one complete SMBus transaction each time it is started. On an accepted start it captures the protocol code, the address byte, the command byte and three data bytes. It then steps through the byte-level primitives that the chosen protocol needs, such as start-for-write, start-for-read, send, receive, nack and stop. The primitives go to a bus master one at a time over a valid/ready command channel, and each one is answered on a separate response channel. Bytes that are received are written into the block's own data registers, and the outcome is reported in four sticky status bits.

Driving SCL and SDA at the bit level is left to the bus master behind the primitive interface. For the two block protocols, only the opening of the transfer and its first data byte are handled. After that the sequencer parks with host-busy and byte-done set, so that a streaming stage can take over.

Top module: `smbus_txn_seq`

## Requirements
- R1: Primitive codes on `cmd_op_o` are 1 start-for-write, 2 start-for-read, 3 send, 4 receive, 5 nack and 6 stop. Every start carries `{1'b0, addr[7:1]}` on `cmd_data_o`. A quick command (protocol 0) is one start whose direction follows `addr[0]` (1 = read), followed by a stop, and it then sets the interrupt bit.
- R2: A byte transfer (protocol 1) written sends the command byte. Read, it receives one byte into data0. A byte-data transfer (protocol 2) always sends the command byte after the first start. Its write sends data0. Its read restarts for read and receives into data0. Every read ends with nack and then stop. Every write ends with stop.
- R3: A word write (protocol 3) sends data0 and then data1. A word read receives the low byte into data0 and then the high byte into data1.
- R4: A process call (protocol 4) ignores `addr[0]`. It writes the command, data0 and data1, restarts for read, and receives into data0 and then data1, followed by nack and stop.
- R5: Block data (protocol 5) read sends the command, restarts for read, receives the count into data0 and the first byte into the block register. Block data written sends the command, data0 as count and then the block byte. Both end with no stop, with host-busy and byte-done set and the interrupt bit clear.
- R6: I2C block read (protocol 6) ignores `addr[0]`. It starts for write, sends data1 as offset, restarts for read and receives the first byte into the block register. It ends with no stop and with host-busy and byte-done set.
- R7: A negative response to a start, send or receive sets device error. The transfer then goes straight to stop, leaves the interrupt bit clear, clears host-busy, and does not store the failed byte.
- R8: Protocol code 7 sets device error with no bus activity and leaves the data registers unchanged.
- R9: A start while device error is set issues no primitive and leaves device error set and the interrupt bit clear.
- R10: While a transaction runs, further starts are ignored and host-busy reads 1.
- R11: After reset all registers and status bits are 0. The status bits are `status_o[0]` host-busy, `[1]` interrupt, `[2]` device error and `[3]` byte-done, and each is cleared by writing 1 to its bit of `sts_clr_i`. A clear of host-busy has no effect while a transaction runs.
- R12: Only one primitive is outstanding at a time. `cmd_op_o` and `cmd_data_o` hold steady while `cmd_valid_o` waits for `cmd_ready_i`, and the next primitive follows only after a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| proto_i | input | 3 | Protocol code |
| addr_i | input | 8 | Target address [7:1], read flag [0] |
| cmd_i | input | 8 | Command byte |
| data0_i | input | 8 | Data0 value captured at start |
| data1_i | input | 8 | Data1 value captured at start |
| blk_i | input | 8 | Block byte captured at start |
| sts_clr_i | input | 4 | Write-1-to-clear mask for status |
| data0_o | output | 8 | Data0 register |
| data1_o | output | 8 | Data1 register |
| blk_o | output | 8 | Block data register |
| status_o | output | 4 | Busy, interrupt, device error, byte-done |
| cmd_valid_o | output | 1 | Primitive request valid |
| cmd_ready_i | input | 1 | Bus master accepts primitive |
| cmd_op_o | output | 3 | Primitive code |
| cmd_data_o | output | 8 | Address or byte to send |
| rsp_valid_i | input | 1 | Primitive completed |
| rsp_ack_i | input | 1 | Target acknowledged |
| rsp_data_i | input | 8 | Received byte |

## Verification
The hardest path to reach is a negative response in the middle of a long sequence. The sequencer must abandon its program there, issue the stop, and leave the data registers as they were. The bench's bus model answers every primitive and drops the acknowledge at a chosen primitive index. Each vector therefore aims the failure at an address phase, a command send, a restart or a receive deep inside a process call. The ignored-start case is reached by pulsing start a few cycles into a running word write and confirming that the recorded primitive trace is unchanged.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ST_W   = 4;
  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_INTR  = 1;
  localparam int unsigned ST_ERR   = 2;
  localparam int unsigned ST_BDONE = 3;

  localparam logic [2:0] PR_QUICK     = 3'd0;
  localparam logic [2:0] PR_BYTE      = 3'd1;
  localparam logic [2:0] PR_BYTE_DATA = 3'd2;
  localparam logic [2:0] PR_WORD      = 3'd3;
  localparam logic [2:0] PR_PROC_CALL = 3'd4;
  localparam logic [2:0] PR_BLOCK     = 3'd5;
  localparam logic [2:0] PR_I2C_BLOCK = 3'd6;

  // OP_NONE and OP_HOLD never reach the bus
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_START_WR = 3'd1,
    OP_START_RD = 3'd2,
    OP_SEND     = 3'd3,
    OP_RECV     = 3'd4,
    OP_NACK     = 3'd5,
    OP_STOP     = 3'd6,
    OP_HOLD     = 3'd7
  } bus_op_e;

  // byte source for sends, destination for receives
  typedef enum logic [2:0] {
    SEL_ADDR = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_D0   = 3'd2,
    SEL_D1   = 3'd3,
    SEL_BLK  = 3'd4
  } sel_e;

  typedef struct packed {
    bus_op_e op;
    sel_e    sel;
  } step_t;

  function automatic step_t mk_step(bus_op_e op, sel_e sel);
    step_t s;
    s.op  = op;
    s.sel = sel;
    return s;
  endfunction

  function automatic logic proto_known(logic [2:0] p);
    return p <= PR_I2C_BLOCK;
  endfunction

endpackage

// File: rtl/smbus_seq_prog.sv
module smbus_seq_prog
  import smbus_seq_pkg::*;
#(
  parameter int unsigned STEP_W = 4
) (
  input  logic [2:0]        proto_i,
  input  logic              rd_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o
);

  localparam int unsigned NSTEP = 1 << STEP_W;

  step_t prog [NSTEP];

  always_comb begin
    for (int i = 0; i < NSTEP; i++) prog[i] = mk_step(OP_NONE, SEL_ADDR);
    case (proto_i)
      PR_QUICK: begin
        prog[0] = mk_step(rd_i ? OP_START_RD : OP_START_WR, SEL_ADDR);
        prog[1] = mk_step(OP_STOP, SEL_ADDR);
      end
      PR_BYTE: begin
        if (rd_i) begin
          prog[0] = mk_step(OP_START_RD, SEL_ADDR);
          prog[1] = mk_step(OP_RECV, SEL_D0);
          prog[2] = mk_step(OP_NACK, SEL_ADDR);
          prog[3] = mk_step(OP_STOP, SEL_ADDR);
        end else begin
          prog[0] = mk_step(OP_START_WR, SEL_ADDR);
          prog[1] = mk_step(OP_SEND, SEL_CMD);
          prog[2] = mk_step(OP_STOP, SEL_ADDR);
        end
      end
      PR_BYTE_DATA: begin
        prog[0] = mk_step(OP_START_WR, SEL_ADDR);
        prog[1] = mk_step(OP_SEND, SEL_CMD);
        if (rd_i) begin
          prog[2] = mk_step(OP_START_RD, SEL_ADDR);
          prog[3] = mk_step(OP_RECV, SEL_D0);
          prog[4] = mk_step(OP_NACK, SEL_ADDR);
          prog[5] = mk_step(OP_STOP, SEL_ADDR);
        end else begin
          prog[2] = mk_step(OP_SEND, SEL_D0);
          prog[3] = mk_step(OP_STOP, SEL_ADDR);
        end
      end
      PR_WORD: begin
        prog[0] = mk_step(OP_START_WR, SEL_ADDR);
        prog[1] = mk_step(OP_SEND, SEL_CMD);
        if (rd_i) begin
          prog[2] = mk_step(OP_START_RD, SEL_ADDR);
          prog[3] = mk_step(OP_RECV, SEL_D0);
          prog[4] = mk_step(OP_RECV, SEL_D1);
          prog[5] = mk_step(OP_NACK, SEL_ADDR);
          prog[6] = mk_step(OP_STOP, SEL_ADDR);
        end else begin
          prog[2] = mk_step(OP_SEND, SEL_D0);
          prog[3] = mk_step(OP_SEND, SEL_D1);
          prog[4] = mk_step(OP_STOP, SEL_ADDR);
        end
      end
      PR_PROC_CALL: begin
        prog[0] = mk_step(OP_START_WR, SEL_ADDR);
        prog[1] = mk_step(OP_SEND, SEL_CMD);
        prog[2] = mk_step(OP_SEND, SEL_D0);
        prog[3] = mk_step(OP_SEND, SEL_D1);
        prog[4] = mk_step(OP_START_RD, SEL_ADDR);
        prog[5] = mk_step(OP_RECV, SEL_D0);
        prog[6] = mk_step(OP_RECV, SEL_D1);
        prog[7] = mk_step(OP_NACK, SEL_ADDR);
        prog[8] = mk_step(OP_STOP, SEL_ADDR);
      end
      PR_BLOCK: begin
        prog[0] = mk_step(OP_START_WR, SEL_ADDR);
        prog[1] = mk_step(OP_SEND, SEL_CMD);
        if (rd_i) begin
          prog[2] = mk_step(OP_START_RD, SEL_ADDR);
          prog[3] = mk_step(OP_RECV, SEL_D0);
          prog[4] = mk_step(OP_RECV, SEL_BLK);
          prog[5] = mk_step(OP_HOLD, SEL_ADDR);
        end else begin
          prog[2] = mk_step(OP_SEND, SEL_D0);
          prog[3] = mk_step(OP_SEND, SEL_BLK);
          prog[4] = mk_step(OP_HOLD, SEL_ADDR);
        end
      end
      PR_I2C_BLOCK: begin
        // direction bit deliberately ignored
        prog[0] = mk_step(OP_START_WR, SEL_ADDR);
        prog[1] = mk_step(OP_SEND, SEL_D1);
        prog[2] = mk_step(OP_START_RD, SEL_ADDR);
        prog[3] = mk_step(OP_RECV, SEL_BLK);
        prog[4] = mk_step(OP_HOLD, SEL_ADDR);
      end
      default: ;
    endcase
  end

  assign step_o = prog[idx_i];

endmodule

// File: rtl/smbus_seq_bus.sv
module smbus_seq_bus
  import smbus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  bus_op_e           op_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_op_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_ack_i,
  input  logic [BYTE_W-1:0] rsp_data_i,
  output logic              done_o,
  output logic              ack_o,
  output logic [BYTE_W-1:0] rdata_o
);

  typedef enum logic [1:0] {B_IDLE, B_CMD, B_RSP} bstate_e;

  bstate_e           st_q;
  bus_op_e           op_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= B_IDLE;
      op_q   <= OP_NONE;
      data_q <= '0;
    end else begin
      case (st_q)
        B_IDLE: if (req_i) begin
          st_q   <= B_CMD;
          op_q   <= op_i;
          data_q <= data_i;
        end
        B_CMD:   if (cmd_ready_i) st_q <= B_RSP;
        B_RSP:   if (rsp_valid_i) st_q <= B_IDLE;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (st_q == B_CMD);
  assign cmd_op_o    = op_q;
  assign cmd_data_o  = data_q;
  assign done_o      = (st_q == B_RSP) && rsp_valid_i;
  assign ack_o       = rsp_ack_i;
  assign rdata_o     = rsp_data_i;

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o)); // R12

endmodule

// File: rtl/smbus_seq_regs.sv
module smbus_seq_regs
  import smbus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] d0_i,
  input  logic [BYTE_W-1:0] d1_i,
  input  logic [BYTE_W-1:0] blk_i,
  input  logic              wr_i,
  input  sel_e              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ST_W-1:0]   sts_set_i,
  input  logic [ST_W-1:0]   sts_clr_i,
  output logic [BYTE_W-1:0] addr_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [BYTE_W-1:0] d0_o,
  output logic [BYTE_W-1:0] d1_o,
  output logic [BYTE_W-1:0] blk_o,
  output logic [ST_W-1:0]   sts_o
);

  logic [BYTE_W-1:0] addr_q, cmd_q, d0_q, d1_q, blk_q;
  logic [ST_W-1:0]   sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cmd_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      blk_q  <= '0;
    end else if (cap_i) begin
      addr_q <= addr_i;
      cmd_q  <= cmd_i;
      d0_q   <= d0_i;
      d1_q   <= d1_i;
      blk_q  <= blk_i;
    end else if (wr_i) begin
      case (wr_sel_i)
        SEL_D0:  d0_q  <= wr_data_i;
        SEL_D1:  d1_q  <= wr_data_i;
        SEL_BLK: blk_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~sts_clr_i) | sts_set_i;
  end

  assign addr_o = addr_q;
  assign cmd_o  = cmd_q;
  assign d0_o   = d0_q;
  assign d1_o   = d1_q;
  assign blk_o  = blk_q;
  assign sts_o  = sts_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q[ST_ERR] && !sts_clr_i[ST_ERR] |=> sts_q[ST_ERR]); // R9
  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[ST_BDONE]) |-> sts_q[ST_BUSY]); // R5

endmodule

// File: rtl/smbus_txn_seq.sv
module smbus_txn_seq
  import smbus_seq_pkg::*;
#(
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        proto_i,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        cmd_i,
  input  logic [7:0]        data0_i,
  input  logic [7:0]        data1_i,
  input  logic [7:0]        blk_i,
  input  logic [3:0]        sts_clr_i,
  output logic [7:0]        data0_o,
  output logic [7:0]        data1_o,
  output logic [7:0]        blk_o,
  output logic [3:0]        status_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_op_o,
  output logic [7:0]        cmd_data_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_ack_i,
  input  logic [7:0]        rsp_data_i
);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_WAIT} state_e;

  state_e            state_q;
  logic [STEP_W-1:0] idx_q;
  logic              err_q;
  logic [2:0]        proto_q;
  bus_op_e           cur_op_q;
  sel_e              cur_sel_q;

  logic              accept, reject, launch, req, wr, fail;
  step_t             step;
  bus_op_e           eff_op;
  logic [BYTE_W-1:0] send_data;
  logic              bus_done, bus_ack;
  logic [BYTE_W-1:0] bus_rdata;
  logic [ST_W-1:0]   sts_set, sts_int_clr, sts_clr_eff, busy_lock;
  logic [BYTE_W-1:0] addr_r, cmd_r, d0_r, d1_r, blk_r;

  assign accept = start_i && (state_q == S_IDLE);
  assign reject = accept && (status_o[ST_ERR] || !proto_known(proto_i));
  assign launch = accept && !reject;

  smbus_seq_prog #(.STEP_W(STEP_W)) u_prog (
    .proto_i (proto_q),
    .rd_i    (addr_r[0]),
    .idx_i   (idx_q),
    .step_o  (step)
  );

  // after a failure the only remaining step is stop
  assign eff_op = err_q ? OP_STOP : step.op;

  always_comb begin
    case (step.sel)
      SEL_CMD: send_data = cmd_r;
      SEL_D0:  send_data = d0_r;
      SEL_D1:  send_data = d1_r;
      SEL_BLK: send_data = blk_r;
      default: send_data = {1'b0, addr_r[BYTE_W-1:1]};
    endcase
  end

  assign fail = bus_done && !bus_ack &&
                (cur_op_q inside {OP_START_WR, OP_START_RD, OP_SEND, OP_RECV});

  always_comb begin
    sts_set     = '0;
    sts_int_clr = '0;
    req         = 1'b0;
    wr          = 1'b0;
    if (reject) sts_set[ST_ERR]  = 1'b1;
    if (launch) sts_set[ST_BUSY] = 1'b1;
    if (state_q == S_STEP) begin
      case (eff_op)
        OP_HOLD: sts_set[ST_BDONE] = 1'b1;
        OP_NONE: begin
          sts_int_clr[ST_BUSY] = 1'b1;
          sts_set[ST_INTR]     = 1'b1;
        end
        default: req = 1'b1;
      endcase
    end
    if (state_q == S_WAIT && bus_done) begin
      if (cur_op_q == OP_STOP) begin
        sts_int_clr[ST_BUSY] = 1'b1;
        if (err_q) sts_set[ST_ERR]  = 1'b1;
        else       sts_set[ST_INTR] = 1'b1;
      end else if (!fail && cur_op_q == OP_RECV) begin
        wr = 1'b1;
      end
    end
  end

  always_comb begin
    busy_lock          = '0;
    busy_lock[ST_BUSY] = (state_q != S_IDLE);
  end
  assign sts_clr_eff = (sts_clr_i & ~busy_lock) | sts_int_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      err_q     <= 1'b0;
      proto_q   <= '0;
      cur_op_q  <= OP_NONE;
      cur_sel_q <= SEL_ADDR;
    end else begin
      case (state_q)
        S_IDLE: if (launch) begin
          state_q <= S_STEP;
          idx_q   <= '0;
          err_q   <= 1'b0;
          proto_q <= proto_i;
        end
        S_STEP: begin
          if (eff_op == OP_HOLD || eff_op == OP_NONE) begin
            state_q <= S_IDLE;
          end else begin
            state_q   <= S_WAIT;
            cur_op_q  <= eff_op;
            cur_sel_q <= step.sel;
          end
        end
        S_WAIT: if (bus_done) begin
          if (cur_op_q == OP_STOP) begin
            state_q <= S_IDLE;
          end else if (fail) begin
            err_q   <= 1'b1;
            state_q <= S_STEP;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_STEP;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  smbus_seq_bus u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .op_i        (eff_op),
    .data_i      (send_data),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_op_o    (cmd_op_o),
    .cmd_data_o  (cmd_data_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ack_i   (rsp_ack_i),
    .rsp_data_i  (rsp_data_i),
    .done_o      (bus_done),
    .ack_o       (bus_ack),
    .rdata_o     (bus_rdata)
  );

  smbus_seq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (launch),
    .addr_i    (addr_i),
    .cmd_i     (cmd_i),
    .d0_i      (data0_i),
    .d1_i      (data1_i),
    .blk_i     (blk_i),
    .wr_i      (wr),
    .wr_sel_i  (cur_sel_q),
    .wr_data_i (bus_rdata),
    .sts_set_i (sts_set),
    .sts_clr_i (sts_clr_eff),
    .addr_o    (addr_r),
    .cmd_o     (cmd_r),
    .d0_o      (d0_r),
    .d1_o      (d1_r),
    .blk_o     (blk_r),
    .sts_o     (status_o)
  );

  assign data0_o = d0_r;
  assign data1_o = d1_r;
  assign blk_o   = blk_r;

  AST_DONE_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_done |-> state_q == S_WAIT); // R12
  AST_IGNORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) && start_i |=> $stable(proto_q)); // R10
  AST_INTR_NOT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_INTR]) |-> !status_o[ST_ERR]); // R7
  AST_REJECT_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> !cmd_valid_o && state_q == S_IDLE); // R8

endmodule

// File: tb/smbus_txn_seq_tb.sv
module smbus_txn_seq_tb;

  typedef struct packed {
    logic [2:0]  proto;
    logic [7:0]  addr;
    logic [3:0]  nack;
    logic [39:0] ops;
    logic [3:0]  n;
    logic [39:0] tx;
    logic [7:0]  d0;
    logic [7:0]  d1;
    logic [7:0]  blk;
    logic [3:0]  sts;
  } vec_t;

  localparam int NV = 18;
  // ops: one nibble per primitive, first in the low nibble; tx: start/send bytes, first in the low byte
  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'hA4, 4'hF, 40'h61,        4'd2, 40'h52,         8'h11, 8'h22, 8'h44, 4'h2}, // R1
    '{3'd0, 8'hA5, 4'hF, 40'h62,        4'd2, 40'h52,         8'h11, 8'h22, 8'h44, 4'h2}, // R1
    '{3'd1, 8'hA4, 4'hF, 40'h631,       4'd3, 40'h3352,       8'h11, 8'h22, 8'h44, 4'h2}, // R2
    '{3'd1, 8'hA5, 4'hF, 40'h6542,      4'd4, 40'h52,         8'hC1, 8'h22, 8'h44, 4'h2}, // R2
    '{3'd2, 8'hA4, 4'hF, 40'h6331,      4'd4, 40'h113352,     8'h11, 8'h22, 8'h44, 4'h2}, // R2
    '{3'd2, 8'hA5, 4'hF, 40'h654231,    4'd6, 40'h523352,     8'hC3, 8'h22, 8'h44, 4'h2}, // R2
    '{3'd3, 8'hA4, 4'hF, 40'h63331,     4'd5, 40'h22113352,   8'h11, 8'h22, 8'h44, 4'h2}, // R3
    '{3'd3, 8'hA5, 4'hF, 40'h6544231,   4'd7, 40'h523352,     8'hC3, 8'hC4, 8'h44, 4'h2}, // R3
    '{3'd4, 8'hA4, 4'hF, 40'h654423331, 4'd9, 40'h5222113352, 8'hC5, 8'hC6, 8'h44, 4'h2}, // R4
    '{3'd5, 8'hA5, 4'hF, 40'h44231,     4'd5, 40'h523352,     8'hC3, 8'h22, 8'hC4, 4'h9}, // R5
    '{3'd5, 8'hA4, 4'hF, 40'h3331,      4'd4, 40'h44113352,   8'h11, 8'h22, 8'h44, 4'h9}, // R5
    '{3'd6, 8'hA5, 4'hF, 40'h4231,      4'd4, 40'h522252,     8'h11, 8'h22, 8'hC3, 4'h9}, // R6
    '{3'd6, 8'hA4, 4'hF, 40'h4231,      4'd4, 40'h522252,     8'h11, 8'h22, 8'hC3, 4'h9}, // R6
    '{3'd2, 8'hA4, 4'h1, 40'h631,       4'd3, 40'h3352,       8'h11, 8'h22, 8'h44, 4'h4}, // R7
    '{3'd3, 8'hA5, 4'h0, 40'h61,        4'd2, 40'h52,         8'h11, 8'h22, 8'h44, 4'h4}, // R7
    '{3'd1, 8'hA5, 4'h1, 40'h642,       4'd3, 40'h52,         8'h11, 8'h22, 8'h44, 4'h4}, // R7
    '{3'd6, 8'hA5, 4'h2, 40'h6231,      4'd4, 40'h522252,     8'h11, 8'h22, 8'h44, 4'h4}, // R7
    '{3'd4, 8'hA4, 4'h5, 40'h6423331,   4'd7, 40'h5222113352, 8'h11, 8'h22, 8'h44, 4'h4}  // R7
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] proto = '0;
  logic [7:0] addr = '0;
  logic [7:0] cmd = 8'h33;
  logic [7:0] d0 = 8'h11;
  logic [7:0] d1 = 8'h22;
  logic [7:0] blk = 8'h44;
  logic [3:0] sts_clr = '0;
  logic [7:0] data0, data1, blkd;
  logic [3:0] status;
  logic       cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [2:0] cmd_op;
  logic [7:0] cmd_data;
  logic       rsp_valid = 1'b0;
  logic       rsp_ack = 1'b0;
  logic [7:0] rsp_data = '0;

  int         checks = 0;
  int         fails = 0;
  bit         finished = 0;

  // bus model state
  logic [3:0]  nack_at = 4'hF;
  int          m_n = 0;
  int          m_tx = 0;
  bit          m_phase = 0;
  logic [39:0] op_log = '0;
  logic [39:0] tx_log = '0;

  always #10 clk = ~clk;

  smbus_txn_seq u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .proto_i     (proto),
    .addr_i      (addr),
    .cmd_i       (cmd),
    .data0_i     (d0),
    .data1_i     (d1),
    .blk_i       (blk),
    .sts_clr_i   (sts_clr),
    .data0_o     (data0),
    .data1_o     (data1),
    .blk_o       (blkd),
    .status_o    (status),
    .cmd_valid_o (cmd_valid),
    .cmd_ready_i (cmd_ready),
    .cmd_op_o    (cmd_op),
    .cmd_data_o  (cmd_data),
    .rsp_valid_i (rsp_valid),
    .rsp_ack_i   (rsp_ack),
    .rsp_data_i  (rsp_data)
  );

  always @(negedge clk) begin
    if (rsp_valid) begin
      rsp_valid = 1'b0;
    end else if (m_phase) begin
      cmd_ready = 1'b0;
      rsp_valid = 1'b1;
      rsp_ack   = (m_n[3:0] != nack_at);
      rsp_data  = 8'hC0 | {4'h0, m_n[3:0]};
      m_n++;
      m_phase = 0;
    end else if (cmd_valid && !cmd_ready && m_n < 10) begin
      op_log[m_n*4 +: 4] = {1'b0, cmd_op};
      if (cmd_op inside {3'd1, 3'd2, 3'd3} && m_tx < 5) begin
        tx_log[m_tx*8 +: 8] = cmd_data;
        m_tx++;
      end
      cmd_ready = 1'b1;
      m_phase = 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_sts(input logic [3:0] m);
    @(negedge clk);
    sts_clr = m;
    @(negedge clk);
    sts_clr = '0;
  endtask

  task automatic launch(input logic [2:0] p, input logic [7:0] a, input logic [3:0] nk);
    @(negedge clk);
    proto = p; addr = a; nack_at = nk;
    m_n = 0; m_tx = 0; op_log = '0; tx_log = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R12 watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev_d0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset status", 64'(status), 64'h0);
    chk("R11 reset data0", 64'(data0), 64'h0);
    chk("R11 reset cmd_valid", 64'(cmd_valid), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clear_sts(4'hF);
      launch(VEC[v].proto, VEC[v].addr, VEC[v].nack);
      repeat (60) @(negedge clk);
      chk($sformatf("R12 v%0d op trace", v), 64'(op_log), 64'(VEC[v].ops));
      chk($sformatf("R12 v%0d op count", v), 64'(m_n), 64'(VEC[v].n));
      chk($sformatf("R1 v%0d sent bytes", v), 64'(tx_log), 64'(VEC[v].tx));
      chk($sformatf("R3 v%0d data0", v), 64'(data0), 64'(VEC[v].d0));
      chk($sformatf("R3 v%0d data1", v), 64'(data1), 64'(VEC[v].d1));
      chk($sformatf("R5 v%0d block", v), 64'(blkd), 64'(VEC[v].blk));
      chk($sformatf("R7 v%0d status", v), 64'(status), 64'(VEC[v].sts));
    end

    // R8 invalid protocol
    clear_sts(4'hF);
    prev_d0 = data0;
    d0 = 8'h77;
    launch(3'd7, 8'hA4, 4'hF);
    repeat (20) @(negedge clk);
    chk("R8 no primitives", 64'(m_n), 64'h0);
    chk("R8 status", 64'(status), 64'h4);
    chk("R8 data0 kept", 64'(data0), 64'(prev_d0));
    d0 = 8'h11;

    // R9 start with device error pending
    launch(3'd1, 8'hA4, 4'hF);
    repeat (20) @(negedge clk);
    chk("R9 no primitives", 64'(m_n), 64'h0);
    chk("R9 status", 64'(status), 64'h4);

    // R11 partial write-1-to-clear after a parked block read
    clear_sts(4'hF);
    launch(3'd6, 8'hA5, 4'hF);
    repeat (40) @(negedge clk);
    chk("R11 parked status", 64'(status), 64'h9);
    clear_sts(4'h8);
    chk("R11 clear byte-done only", 64'(status), 64'h1);

    // R10 second start during a running word write, busy clear locked
    clear_sts(4'hF);
    launch(3'd3, 8'hA4, 4'hF);
    repeat (3) @(negedge clk);
    chk("R10 busy while running", 64'(status[0]), 64'h1);
    proto = 3'd0; addr = 8'hA5; sts_clr = 4'h1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; sts_clr = '0;
    chk("R11 busy clear locked", 64'(status[0]), 64'h1);
    repeat (60) @(negedge clk);
    chk("R10 trace unchanged", 64'(op_log), 64'h63331);
    chk("R10 op count", 64'(m_n), 64'd5);
    chk("R10 status", 64'(status), 64'h2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule